// File: doc/BRIEF.md
# Serial Shift-Clock Bit Counter With Wait

This block follows the bit position of an 8-bit serial transfer by watching the shift-clock pin. The block samples the pin with the system clock and does not care whether the channel or an outside master drives it. A falling pin edge advances the bit count. Once the count holds the full byte, the next rising pin edge returns the count to zero and parks the channel in a wait state. It marks that moment with a one-cycle byte-complete pulse.

While waiting, the counter is frozen and ignores pin activity. A release strobe leaves the wait state with the count at zero, so the next falling edge is bit 1. Four conditions clear the count and force the wait state, and each overrides any pin edge in the same cycle: power-on reset (active-low `rst_n`), a clock-stop strobe, a forced-wait strobe and a chip-enable reset strobe. Only the wait flag and the completion pulse leave the block. The count itself stays internal.

The controller has three states. `ST_WAIT` is frozen with the count at 0. `ST_SHIFT` counts falling edges. `ST_FULL` holds the count at 8 and waits for the final rise. The transitions are:
- **start**: `ST_WAIT` to `ST_SHIFT` on release.
- **fill**: `ST_SHIFT` to `ST_FULL` on the 8th falling edge.
- **wrap**: `ST_FULL` to `ST_WAIT` on a rising edge, with a pulse.
- **abort**: any state to `ST_WAIT` on a clear source.

Top module: `sclk_bit_counter`

## Requirements
- R1: During and directly after power-on reset (`rst_n` low), `wait_o` is 1 and `byte_done_o` is 0. A reset in the middle of a transfer discards the partial count.
- R2: In the wait state, a cycle with `release_i` high and no clear source active makes `wait_o` 0 from the next cycle on.
- R3: Outside wait, each falling pin edge adds one to the count. After the 8th falling edge, the following rising edge sets `wait_o` to 1 and raises `byte_done_o`. The count never exceeds 8.
- R4: Rising edges while the count is below 8, and fewer than 8 falling edges, never complete a transfer.
- R5: While `wait_o` is 1, pin edges are ignored and the count stays 0. Completing a byte after release takes a full 8 new falling edges.
- R6: A `force_wait_i` cycle sets `wait_o` to 1 on the next cycle and zeroes the count.
- R7: A `clk_stop_i` cycle sets `wait_o` to 1 on the next cycle and zeroes the count.
- R8: A `ce_rst_i` cycle sets `wait_o` to 1 on the next cycle and zeroes the count.
- R9: When a clear source and the completing rising edge land in the same cycle, the clear wins and no `byte_done_o` pulse is produced.
- R10: A pin transition passes through a two-flop synchronizer and an edge detector. A rise that completes a byte shows on `wait_o` and `byte_done_o` after the third system-clock edge following the pin change, and not before.
- R11: `release_i` while not in wait has no effect on the count; the transfer still completes after exactly 8 falling edges in total.
- R12: `byte_done_o` lasts exactly one cycle and is only high in the first cycle of a wait entered by wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sclk_pin_i | input | 1 | Raw shift-clock pin level |
| release_i | input | 1 | Start / wait-release strobe |
| force_wait_i | input | 1 | Forced-wait strobe |
| clk_stop_i | input | 1 | Clock-stop strobe |
| ce_rst_i | input | 1 | Chip-enable reset strobe |
| wait_o | output | 1 | Serial channel is in the wait state |
| byte_done_o | output | 1 | One-cycle pulse when a byte completes |

## Verification
The assertions check the following on every cycle:
- the hidden count never passing 8;
- the completion pulse being single-cycle, inside wait and entered from running;
- each clear strobe forcing wait with no pulse;
- release leaving wait;
- the wait state holding a zero count.

Only the bench scenarios can show the behaviour that depends on edge counts over many cycles:
- that exactly eight falling edges are needed;
- that edges during wait or a stray release leave the count alone;
- that a reset or clear mid-transfer restarts the count;
- the exact three-edge latency from pin to output.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } sbc_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sbc_edge_t;

endpackage

// File: rtl/sbc_edge_det.sv
module sbc_edge_det
    import sbc_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LVL    = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    output sbc_edge_t edge_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // synchronizer chain, one flop per stage
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        logic d;
        if (g == 0) begin : g_first
            assign d = pin_i;
        end else begin : g_next
            assign d = sync_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[g] <= IDLE_LVL;
            else        sync_q[g] <= d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_LVL;
        else        prev_q <= sync_q[LAST];
    end

    always_comb begin
        edge_o.rise = sync_q[LAST] & ~prev_q;
        edge_o.fall = ~sync_q[LAST] & prev_q;
    end
endmodule

// File: rtl/sbc_clr_merge.sv
module sbc_clr_merge #(
    parameter int N_SRC = 3
) (
    input  logic [N_SRC-1:0] clr_src_i,
    input  logic             release_i,
    output logic             clear_o,
    output logic             release_o
);
    // any clear source outranks release and pin edges
    always_comb begin
        clear_o   = |clr_src_i;
        release_o = release_i & ~clear_o;
    end
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
    import sbc_pkg::*;
#(
    parameter int BITS  = 8,
    parameter int CNT_W = $clog2(BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             release_i,
    input  sbc_edge_t        edge_i,
    output logic             wait_o,
    output logic             done_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(BITS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    sbc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wrap;
    logic             done_q;

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wrap    = 1'b0;
        if (clear_i) begin
            state_d = ST_WAIT;                  // abort
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (release_i) state_d = ST_SHIFT;   // start
                end
                ST_SHIFT: begin
                    if (edge_i.fall) begin
                        cnt_d = cnt_q + CNT_ONE;
                        if (cnt_q == CNT_PRE) state_d = ST_FULL; // fill
                    end
                end
                ST_FULL: begin
                    if (edge_i.rise) begin
                        cnt_d   = '0;
                        state_d = ST_WAIT;      // wrap
                        wrap    = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_WAIT;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= wrap;
    end

    assign wait_o = (state_q == ST_WAIT);
    assign done_o = done_q;
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/sclk_bit_counter.sv
module sclk_bit_counter
    import sbc_pkg::*;
#(
    parameter int   BITS        = 8,
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LVL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_pin_i,
    input  logic release_i,
    input  logic force_wait_i,
    input  logic clk_stop_i,
    input  logic ce_rst_i,
    output logic wait_o,
    output logic byte_done_o
);
    localparam int N_CLR = 3;
    localparam int CNT_W = $clog2(BITS + 1);

    sbc_edge_t        pin_edge;
    logic             clear;
    logic             release_ok;
    logic [CNT_W-1:0] bit_cnt;

    sbc_edge_det #(
        .SYNC_STAGES (SYNC_STAGES),
        .IDLE_LVL    (IDLE_LVL)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (sclk_pin_i),
        .edge_o (pin_edge)
    );

    sbc_clr_merge #(
        .N_SRC (N_CLR)
    ) u_merge (
        .clr_src_i ({ce_rst_i, clk_stop_i, force_wait_i}),
        .release_i (release_i),
        .clear_o   (clear),
        .release_o (release_ok)
    );

    sbc_ctrl #(
        .BITS  (BITS),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .release_i (release_ok),
        .edge_i    (pin_edge),
        .wait_o    (wait_o),
        .done_o    (byte_done_o),
        .cnt_o     (bit_cnt)
    );
endmodule

// File: rtl/sclk_bit_counter_chk.sv
module sclk_bit_counter_chk #(
    parameter int BITS  = 8,
    parameter int CNT_W = $clog2(BITS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             release_i,
    input logic             force_wait_i,
    input logic             clk_stop_i,
    input logic             ce_rst_i,
    input logic             wait_o,
    input logic             byte_done_o,
    input logic [CNT_W-1:0] bit_cnt
);
    logic any_clr;
    assign any_clr = force_wait_i | clk_stop_i | ce_rst_i;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(BITS)); // R3

    AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_o |-> $past(!wait_o)); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_o |=> !byte_done_o); // R12

    AST_DONE_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_o |-> wait_o); // R12

    AST_RELEASE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_o && release_i && !any_clr) |=> !wait_o); // R2

    AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_o && !release_i) |=> (wait_o && bit_cnt == '0)); // R5

    AST_FORCE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        force_wait_i |=> (wait_o && bit_cnt == '0)); // R6

    AST_STOP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_i |=> (wait_o && bit_cnt == '0)); // R7

    AST_CE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ce_rst_i |=> (wait_o && bit_cnt == '0)); // R8

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        any_clr |=> !byte_done_o); // R9
endmodule

bind sclk_bit_counter sclk_bit_counter_chk #(
    .BITS  (BITS),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .release_i    (release_i),
    .force_wait_i (force_wait_i),
    .clk_stop_i   (clk_stop_i),
    .ce_rst_i     (ce_rst_i),
    .wait_o       (wait_o),
    .byte_done_o  (byte_done_o),
    .bit_cnt      (bit_cnt)
);

// File: tb/tb_sclk_bit_counter.sv
module tb_sclk_bit_counter;
    localparam int BITS = 8;
    localparam int HALF = 4;   // system cycles per shift-clock half period

    logic clk = 1'b0;
    always #4 clk = ~clk;      // 125 MHz

    logic rst_n = 1'b0;
    logic pin = 1'b1;
    logic rel = 1'b0;
    logic fw = 1'b0;
    logic cs = 1'b0;
    logic ce = 1'b0;
    logic wait_w;
    logic done_w;

    sclk_bit_counter #(.BITS(BITS)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_pin_i   (pin),
        .release_i    (rel),
        .force_wait_i (fw),
        .clk_stop_i   (cs),
        .ce_rst_i     (ce),
        .wait_o       (wait_w),
        .byte_done_o  (done_w)
    );

    int    total = 0;
    int    bad = 0;
    int    dones = 0;
    string req = "R1";
    bit    finished = 1'b0;

    // behavioural reference: pin samples kept in a short history queue
    bit m_wait = 1'b1;
    bit m_done = 1'b0;
    int m_cnt = 0;
    bit hist[$] = '{1'b1, 1'b1, 1'b1};

    always @(posedge clk) begin
        bit rise;
        bit fall;
        rise = hist[1] && !hist[2];
        fall = !hist[1] && hist[2];
        if (!rst_n) begin
            hist = '{1'b1, 1'b1, 1'b1};
            m_wait = 1'b1;
            m_cnt = 0;
            m_done = 1'b0;
        end else begin
            hist.push_front(pin);
            void'(hist.pop_back());
            m_done = 1'b0;
            if (fw || cs || ce) begin
                m_wait = 1'b1;
                m_cnt = 0;
            end else if (m_wait) begin
                if (rel) m_wait = 1'b0;
            end else if (fall && m_cnt < BITS) begin
                m_cnt++;
            end else if (rise && m_cnt == BITS) begin
                m_cnt = 0;
                m_wait = 1'b1;
                m_done = 1'b1;
            end
        end
    end

    task automatic check(string r, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check(req, int'(wait_w), int'(m_wait), "wait_o vs model");
        check(req, int'(done_w), int'(m_done), "byte_done_o vs model");
        if (done_w) dones++;
    endtask

    task automatic idle(int n);
        repeat (n) step();
    endtask

    task automatic bits(int n);
        repeat (n) begin
            pin = 1'b0;
            idle(HALF);
            pin = 1'b1;
            idle(HALF);
        end
    endtask

    task automatic release_now();
        rel = 1'b1;
        step();
        rel = 1'b0;
    endtask

    task automatic clear_pulse(int sel);
        case (sel)
            0: fw = 1'b1;
            1: cs = 1'b1;
            default: ce = 1'b1;
        endcase
        step();
        fw = 1'b0;
        cs = 1'b0;
        ce = 1'b0;
    endtask

    task automatic abort_run(string r, int sel);
        req = r;
        release_now();
        bits(4);
        clear_pulse(sel);
        check(r, int'(wait_w), 1, "wait after clear");
        dones = 0;
        release_now();
        bits(7);
        check(r, dones, 0, "no early completion after clear");
        bits(1);
        idle(2);
        check(r, dones, 1, "completion after 8 fresh bits");
    endtask

    initial begin
        // R1 reset state
        req = "R1";
        idle(3);
        check("R1", int'(wait_w), 1, "wait in reset");
        check("R1", int'(done_w), 0, "done in reset");
        rst_n = 1'b1;
        idle(2);
        check("R1", int'(wait_w), 1, "wait after reset");

        // R2 release
        req = "R2";
        release_now();
        check("R2", int'(wait_w), 0, "wait after release");

        // R3 / R4 / R10 / R12 full byte with exact latency
        req = "R4";
        dones = 0;
        bits(7);
        check("R4", dones, 0, "no completion after 7 bits");
        req = "R3";
        pin = 1'b0;
        idle(HALF);
        check("R4", int'(wait_w), 0, "8 falls alone do not complete");
        pin = 1'b1;
        idle(2);
        check("R10", int'(wait_w), 0, "wrap not visible after 2 edges");
        step();
        check("R10", int'(wait_w), 1, "wait after 3 edges");
        check("R3", int'(done_w), 1, "done pulse on wrap");
        step();
        check("R12", int'(done_w), 0, "done lasts one cycle");
        check("R3", dones, 1, "one completion per byte");

        // R5 edges during wait ignored
        req = "R5";
        dones = 0;
        bits(3);
        check("R5", int'(wait_w), 1, "still waiting");
        check("R5", dones, 0, "no completion in wait");
        release_now();
        bits(7);
        check("R5", dones, 0, "wait edges were not counted");
        bits(1);
        idle(2);
        check("R5", dones, 1, "completion after 8 new bits");

        // R6 / R7 / R8 clear sources
        abort_run("R6", 0);
        abort_run("R7", 1);
        abort_run("R8", 2);

        // R9 clear together with the completing rise
        req = "R9";
        dones = 0;
        release_now();
        bits(7);
        pin = 1'b0;
        idle(HALF);
        pin = 1'b1;
        idle(2);
        fw = 1'b1;
        step();
        fw = 1'b0;
        check("R9", int'(done_w), 0, "no pulse when clear coincides");
        check("R9", int'(wait_w), 1, "wait after clear");
        idle(4);
        check("R9", dones, 0, "no completion counted");

        // R11 release while running
        req = "R11";
        dones = 0;
        release_now();
        bits(4);
        release_now();
        bits(3);
        check("R11", dones, 0, "release did not restart count early");
        bits(1);
        idle(2);
        check("R11", dones, 1, "completes after 8 total");

        // R1 reset mid-transfer
        req = "R1";
        dones = 0;
        release_now();
        bits(3);
        rst_n = 1'b0;
        step();
        check("R1", int'(wait_w), 1, "wait during mid-run reset");
        rst_n = 1'b1;
        idle(2);
        release_now();
        bits(7);
        check("R1", dones, 0, "partial count discarded");
        bits(1);
        idle(2);
        check("R1", dones, 1, "completion after reset restart");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule